// File: doc/BRIEF.md
# Clock Fallback Sequencer for Source Retuning

This block keeps a processor clock alive while the PLL that feeds it is being reprogrammed. Before the rate changes, a controller raises a fallback event. The block records which input the top-level clock selector is using. It then writes the selector to the fixed, always-running fallback input (index 0) and holds off for a settling interval before it acknowledges. Once the PLL has been retuned, or the retune has been abandoned, a restore event writes the recorded input back, waits the same interval and acknowledges again.

Events arrive as a valid strobe with a two-bit code. The selector is driven through a value bus and a one-cycle write strobe, and its current setting is read back on an input. The settling interval is counted in reference-clock cycles: a cycles-per-microsecond parameter multiplied by a microsecond count, which defaults to 100. Codes outside the known set only raise a warning pulse. While a switch or its settling wait is in progress the block reports busy, and it ignores every new event.

Top module: `clk_fallback_seq`

## Requirements
- R1: After reset, sel_we_o, busy_o, ack_o, ack_ok_o and warn_o are all 0.
- R2: Event codes are 0 = fallback, 1 = restore after change, 2 = restore after abort, 3 = unrecognised. When a fallback event (code 0) is accepted while idle, the block samples cur_sel_i at that clock edge. In the next cycle it asserts sel_we_o for exactly one cycle with sel_o equal to 0.
- R3: busy_o rises in the cycle after an accepted switch and stays high for exactly CYC_PER_US*WAIT_US cycles. In the cycle busy_o first falls, ack_o and ack_ok_o are both 1 for one cycle.
- R4: When a restore-after-change event (code 1) is accepted while a record is held, the block writes the recorded value with a one-cycle sel_we_o in the next cycle. It then applies the same wait and success acknowledge as R3, and the record is released.
- R5: A restore-after-abort event (code 2) behaves exactly like code 1.
- R6: A restore event (code 1 or 2) with no record held causes no write and no busy period. In the next cycle it gives one cycle of ack_o=1 with ack_ok_o=0.
- R7: A fallback event accepted while a record is already held writes 0 again but keeps the earlier record, so a later restore returns the value captured by the first fallback.
- R8: An unrecognised event (code 3) accepted while idle gives a one-cycle warn_o in the next cycle. It gives no write, no busy and no acknowledge.
- R9: Every event that arrives while busy_o is 1 is ignored. It causes no write, no warning and no change to the held record, and it does not shorten or lengthen the wait.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| evt_valid_i | input | 1 | Event strobe, one cycle |
| evt_code_i | input | 2 | Event code (0 fallback, 1 restore, 2 abort restore, 3 other) |
| cur_sel_i | input | SEL_W | Current selector setting read back from the clock mux |
| sel_o | output | SEL_W | Selector value to write |
| sel_we_o | output | 1 | One-cycle selector write strobe |
| busy_o | output | 1 | Switch or settling wait in progress |
| ack_o | output | 1 | One-cycle completion pulse |
| ack_ok_o | output | 1 | Completion status, 1 = success, valid with ack_o |
| warn_o | output | 1 | One-cycle pulse for an unrecognised event |

## Verification
The assertions assume that cur_sel_i is stable at the edge where a fallback is accepted, and that evt_code_i is meaningful whenever evt_valid_i is high. The stimulus changes inputs only at falling edges and holds each event strobe for a single cycle. It updates cur_sel_i well before the event that samples it. Events sent during a busy period are timed to land strictly inside the wait, so the ignore rule is exercised without the stimulus racing the acknowledge edge.

// File: rtl/clk_fb_pkg.sv
package clk_fb_pkg;
  typedef enum logic [1:0] {
    EV_FALL  = 2'd0,
    EV_POST  = 2'd1,
    EV_ABORT = 2'd2,
    EV_OTHER = 2'd3
  } evt_e;
endpackage

// File: rtl/clk_fb_decode.sv
module clk_fb_decode
  import clk_fb_pkg::*;
(
  input  logic       valid_i,
  input  logic [1:0] code_i,
  input  logic       busy_i,
  output logic       fall_o,
  output logic       restore_o,
  output logic       warn_o
);
  evt_e ev;
  logic take;

  always_comb begin
    ev        = evt_e'(code_i);
    take      = valid_i && !busy_i;
    fall_o    = take && (ev == EV_FALL);
    restore_o = take && ((ev == EV_POST) || (ev == EV_ABORT));
    warn_o    = take && (ev == EV_OTHER);
  end
endmodule

// File: rtl/clk_fb_timer.sv
module clk_fb_timer #(
  parameter int unsigned WAIT_CYC = 400
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic expire_o
);
  localparam int unsigned CW = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;
  localparam logic [CW-1:0] LOAD = CW'(WAIT_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          run_q;

  assign expire_o = run_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= LOAD;
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - CW'(1);
    end
  end

  // R3
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && cnt_q != '0 && !start_i) |=> (run_q && cnt_q == $past(cnt_q) - CW'(1)));

  // R3
  expire_ends_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_o && !start_i) |=> !run_q);
endmodule

// File: rtl/clk_fallback_seq.sv
module clk_fallback_seq #(
  parameter int unsigned SEL_W        = 2,
  parameter int unsigned CYC_PER_US   = 4,
  parameter int unsigned WAIT_US      = 100,
  parameter int unsigned FALLBACK_IDX = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evt_valid_i,
  input  logic [1:0]       evt_code_i,
  input  logic [SEL_W-1:0] cur_sel_i,
  output logic [SEL_W-1:0] sel_o,
  output logic             sel_we_o,
  output logic             busy_o,
  output logic             ack_o,
  output logic             ack_ok_o,
  output logic             warn_o
);
  localparam int unsigned WAIT_CYC = CYC_PER_US * WAIT_US;
  localparam logic [SEL_W-1:0] FB_SEL = SEL_W'(FALLBACK_IDX);

  logic do_fall, do_restore, do_warn, tmr_start, tmr_expire;
  logic [SEL_W-1:0] saved_q, sel_q;
  logic rec_q, busy_q, we_q, ack_q, ok_q, warn_q;

  clk_fb_decode u_dec (
    .valid_i  (evt_valid_i),
    .code_i   (evt_code_i),
    .busy_i   (busy_q),
    .fall_o   (do_fall),
    .restore_o(do_restore),
    .warn_o   (do_warn)
  );

  assign tmr_start = do_fall || (do_restore && rec_q);

  clk_fb_timer #(.WAIT_CYC(WAIT_CYC)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (tmr_start),
    .expire_o(tmr_expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      saved_q <= '0;
      sel_q   <= FB_SEL;
      rec_q   <= 1'b0;
      busy_q  <= 1'b0;
      we_q    <= 1'b0;
      ack_q   <= 1'b0;
      ok_q    <= 1'b0;
      warn_q  <= 1'b0;
    end else begin
      we_q   <= 1'b0;
      ack_q  <= 1'b0;
      ok_q   <= 1'b0;
      warn_q <= 1'b0;
      if (do_fall) begin
        // first fallback owns the record; a repeat must not capture the fallback index
        if (!rec_q) begin
          saved_q <= cur_sel_i;
          rec_q   <= 1'b1;
        end
        sel_q  <= FB_SEL;
        we_q   <= 1'b1;
        busy_q <= 1'b1;
      end else if (do_restore) begin
        if (rec_q) begin
          sel_q  <= saved_q;
          we_q   <= 1'b1;
          busy_q <= 1'b1;
          rec_q  <= 1'b0;
        end else begin
          ack_q <= 1'b1;
        end
      end else if (do_warn) begin
        warn_q <= 1'b1;
      end
      if (busy_q && tmr_expire) begin
        busy_q <= 1'b0;
        ack_q  <= 1'b1;
        ok_q   <= 1'b1;
      end
    end
  end

  assign sel_o    = sel_q;
  assign sel_we_o = we_q;
  assign busy_o   = busy_q;
  assign ack_o    = ack_q;
  assign ack_ok_o = ok_q;
  assign warn_o   = warn_q;

  // R2
  fall_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_i && evt_code_i == 2'd0 && !busy_o) |=> (sel_we_o && sel_o == FB_SEL && busy_o));

  // R3
  ok_ack_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && ack_ok_o) |-> (!busy_o && $past(busy_o)));

  // R6
  fail_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && !ack_ok_o) |-> (!sel_we_o && !busy_o));

  // R8
  warn_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warn_o |-> (!sel_we_o && !ack_o));

  // R9
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !tmr_expire) |=> (!sel_we_o && !warn_o && !ack_o && busy_o));

  // R4
  we_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_we_o |=> !sel_we_o);
endmodule

// File: tb/sim_clk_fallback_seq.sv
module sim_clk_fallback_seq;
  localparam int CLK_PERIOD = 10;
  localparam int SEL_W = 2;
  localparam int CPU = 3;
  localparam int WUS = 4;
  localparam int WAIT_CYC = CPU * WUS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_v = 1'b0;
  logic [1:0] ev_c = 2'd0;
  logic [SEL_W-1:0] cur = '0;
  logic [SEL_W-1:0] sel;
  logic we, busy, ack, ok, warn;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clk_fallback_seq #(.SEL_W(SEL_W), .CYC_PER_US(CPU), .WAIT_US(WUS), .FALLBACK_IDX(0)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .evt_valid_i(ev_v), .evt_code_i(ev_c), .cur_sel_i(cur),
    .sel_o(sel), .sel_we_o(we), .busy_o(busy), .ack_o(ack), .ack_ok_o(ok), .warn_o(warn)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive one event; returns at the falling edge just after the accepting edge
  task automatic send(input logic [1:0] code);
    @(negedge clk);
    ev_v = 1'b1;
    ev_c = code;
    @(negedge clk);
    ev_v = 1'b0;
  endtask

  // counts busy cycles from the current sample, then checks the success ack
  task automatic finish_wait(input string req);
    int n = 0;
    while (busy && n < 1000) begin
      n++;
      if (n == 2) chk({req, " we pulse one cycle"}, int'(we), 0);
      @(negedge clk);
    end
    chk({req, " busy length"}, n, WAIT_CYC);
    chk({req, " ack"}, int'(ack), 1);
    chk({req, " ack_ok"}, int'(ok), 1);
    @(negedge clk);
    chk({req, " ack one cycle"}, int'(ack), 0);
  endtask

  task automatic t_reset();
    chk("R1 sel_we", int'(we), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 ack", int'(ack), 0);
    chk("R1 ack_ok", int'(ok), 0);
    chk("R1 warn", int'(warn), 0);
  endtask

  task automatic t_fall(input logic [SEL_W-1:0] c, input string req);
    cur = c;
    send(2'd0);
    chk({req, " sel_we"}, int'(we), 1);
    chk({req, " sel value"}, int'(sel), 0);
    chk({req, " busy rise"}, int'(busy), 1);
    cur = '0;
    finish_wait("R3");
  endtask

  task automatic t_restore(input logic [1:0] code, input int exp, input string req);
    send(code);
    chk({req, " sel_we"}, int'(we), 1);
    chk({req, " restored sel"}, int'(sel), exp);
    cur = SEL_W'(exp);
    finish_wait(req);
  endtask

  task automatic t_no_record(input logic [1:0] code);
    send(code);
    chk("R6 no write", int'(we), 0);
    chk("R6 no busy", int'(busy), 0);
    chk("R6 ack", int'(ack), 1);
    chk("R6 ack_ok low", int'(ok), 0);
    @(negedge clk);
    chk("R6 ack one cycle", int'(ack), 0);
  endtask

  task automatic t_unknown();
    send(2'd3);
    chk("R8 warn", int'(warn), 1);
    chk("R8 no write", int'(we), 0);
    chk("R8 no busy", int'(busy), 0);
    chk("R8 no ack", int'(ack), 0);
    @(negedge clk);
    chk("R8 warn one cycle", int'(warn), 0);
  endtask

  task automatic t_double_fall();
    t_fall(2'd1, "R7 first");
    cur = '0;
    send(2'd0);
    chk("R7 second write", int'(we), 1);
    chk("R7 second sel", int'(sel), 0);
    finish_wait("R7");
    t_restore(2'd1, 1, "R7 keeps first record");
  endtask

  task automatic t_busy_ignore();
    int n = 1;
    cur = 2'd2;
    send(2'd0);
    chk("R9 fall accepted", int'(we), 1);
    cur = '0;
    // three events inside the wait: fallback, unrecognised, restore
    for (int k = 0; k < 3; k++) begin
      ev_v = 1'b1;
      ev_c = (k == 0) ? 2'd0 : (k == 1) ? 2'd3 : 2'd1;
      @(negedge clk);
      ev_v = 1'b0;
      n++;
      chk("R9 no write", int'(we), 0);
      chk("R9 no warn", int'(warn), 0);
      chk("R9 still busy", int'(busy), 1);
    end
    while (busy && n < 1000) begin
      @(negedge clk);
      if (busy) n++;
    end
    chk("R9 busy length", n, WAIT_CYC);
    chk("R9 ack", int'(ack), 1);
    @(negedge clk);
    t_restore(2'd1, 2, "R9 record untouched");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R3 actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2 + 3);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fall(2'd2, "R2");
    t_restore(2'd1, 2, "R4");
    t_no_record(2'd1);
    t_fall(2'd3, "R2 code0 sel3");
    t_restore(2'd2, 3, "R5");
    t_no_record(2'd2);
    t_double_fall();
    t_unknown();
    t_busy_ignore();
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule